// File: doc/BRIEF.md
# Four-Channel Serial DAC Write Sequencer

This block sits between a simple parallel request port and the three-wire serial control interface of a quad 12-bit digital-to-analog converter. A request names one of four channels, gives a 12-bit output code, and may ask for a clear of all outputs before the write. It also says which level that clear resets the outputs to. The block captures the request, builds a 16-bit frame and, if asked, first pulses the clear line. It then lowers chip-select, shifts the frame out most significant bit first on a serial clock that idles high, pulses the load strobe to latch the converter register, and releases chip-select.

The host watches `busy` and issues a new request only when it is low. Completion is reported by a one-cycle `done` pulse. The serial clock rate, the clear and load pulse widths and the chip-select setup gap are parameters counted in system clocks.

Top module: `dacw_ctrl`

## Requirements
- R1: Each write shifts exactly 16 bits, most significant bit first. Bits 15:14 hold the channel, bits 13:12 are zero and bits 11:0 hold the code, with bit 11 as the code's MSB.
- R2: The channel field in frame bits 15:14 is 2'b00 for channel A, 2'b01 for B, 2'b10 for C and 2'b11 for D, taken unchanged from `req_chan`.
- R3: `dac_sclk` idles high. Each low phase and each high phase between bits lasts CLK_DIV/2 system clocks. `dac_sdi` changes only at a falling edge of `dac_sclk` and is stable across every rising edge.
- R4: While `busy` is low, `dac_cs_n`, `dac_ld_n`, `dac_clr_n` and `dac_sclk` are high and `dac_sdi` is low. The same levels hold after reset.
- R5: When `req_clear` is 1 at acceptance, `dac_clr_n` is pulsed low for CLR_W system clocks while chip-select is high, and it returns high before chip-select falls. When `req_clear` is 0, no clear pulse occurs.
- R6: `dac_clrsel` selects the clear level: 0 means zero-scale and 1 means mid-scale. It resets to 1, takes `req_clr_mid` on every accepted request, and holds steady during a transaction.
- R7: `dac_cs_n` is low for exactly CS_SETUP system clocks before the first falling edge of `dac_sclk`. Exactly 16 rising edges occur while it is low.
- R8: After the 16th rising edge, `dac_ld_n` pulses low for LD_W system clocks while chip-select is low. `dac_cs_n` returns high only after the load strobe is high again.
- R9: `done` is high for exactly one cycle per write. That cycle is the first one in which `dac_cs_n` is high again, and `busy` is low in it.
- R10: A request is accepted only when `req_valid` is 1 and `busy` is 0. A request raised while busy is ignored and starts no transaction.
- R11: The channel, code, clear flag and clear level are captured on the accepting cycle. Later changes on the request inputs do not alter the frame in progress.
- R12: `busy` rises in the cycle after acceptance and stays high until the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_chan | input | 2 | Channel select (00=A, 01=B, 10=C, 11=D) |
| req_code | input | 12 | Output code for the selected channel |
| req_clear | input | 1 | Pulse the clear line before the write |
| req_clr_mid | input | 1 | Clear level: 0 zero-scale, 1 mid-scale |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data to the converter |
| dac_cs_n | output | 1 | Chip-select, active low |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear, active low |
| dac_clrsel | output | 1 | Clear-level select |

## Verification
The assertions assume that the host raises `req_valid` only as a request strobe. Once a write is under way, the inputs may change freely. They also assume the timing parameters satisfy the stated minimum of half an SCLK period, so the checks on pin ordering do not depend on pulse width. The stimulus keeps junk on the request inputs, with `req_valid` high, for several cycles into every transaction, then drops it well before `busy` falls. As a result, every accepted request is a deliberate one, while capture and busy-gating are still exercised on every write.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  localparam int CHAN_W  = 2;
  localparam int CODE_W  = 12;
  localparam int PAD_W   = 2;
  localparam int FRAME_W = CHAN_W + PAD_W + CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_CLR_REC,
    ST_SETUP,
    ST_SHIFT,
    ST_LOAD,
    ST_LOAD_REC,
    ST_FIN
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [CHAN_W-1:0] chan,
    input logic [CODE_W-1:0] code
  );
    return {chan, {PAD_W{1'b0}}, code};
  endfunction

endpackage

// File: rtl/dacw_req_capture.sv
module dacw_req_capture
  import dacw_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [CHAN_W-1:0]   in_chan,
  input  logic [CODE_W-1:0]   in_code,
  input  logic                in_mid,
  output logic [FRAME_W-1:0]  frame,
  output logic                clrsel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame  <= '0;
      clrsel <= 1'b1;
    end else if (fire) begin
      frame  <= pack_frame(in_chan, in_code);
      clrsel <= in_mid;
    end
  end

endmodule

// File: rtl/dacw_bit_timer.sv
module dacw_bit_timer #(
  parameter int CLK_DIV = 32,
  parameter int NBITS   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  output logic                     sclk_low,
  output logic [$clog2(NBITS)-1:0] bit_idx,
  output logic                     last_tick
);

  localparam int PW   = $clog2(CLK_DIV);
  localparam int BW   = $clog2(NBITS);
  localparam int HALF = CLK_DIV / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (phase == PW'(CLK_DIV - 1)) begin
      phase   <= '0;
      bit_idx <= bit_idx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign sclk_low  = (phase < PW'(HALF));
  assign last_tick = run && (bit_idx == BW'(NBITS - 1)) &&
                     (phase == PW'(CLK_DIV - 1));

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq
  import dacw_pkg::*;
#(
  parameter int CLR_W    = 16,
  parameter int LD_W     = 16,
  parameter int CS_SETUP = 16,
  parameter int HALF     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       want_clear,
  input  logic       shift_last,
  output seq_state_t state
);

  localparam int M1   = (CLR_W > LD_W) ? CLR_W : LD_W;
  localparam int M2   = (CS_SETUP > HALF) ? CS_SETUP : HALF;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] tmr;
  wire           tmr_end = (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fire) begin
            if (want_clear) begin
              state <= ST_CLR;
              tmr   <= CW'(CLR_W - 1);
            end else begin
              state <= ST_SETUP;
              tmr   <= CW'(CS_SETUP - 1);
            end
          end
        end
        ST_CLR: begin
          if (tmr_end) begin
            state <= ST_CLR_REC;
            tmr   <= CW'(HALF - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_CLR_REC: begin
          if (tmr_end) begin
            state <= ST_SETUP;
            tmr   <= CW'(CS_SETUP - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_SETUP: begin
          if (tmr_end) state <= ST_SHIFT;
          else         tmr   <= tmr - 1'b1;
        end
        ST_SHIFT: begin
          if (shift_last) begin
            state <= ST_LOAD;
            tmr   <= CW'(LD_W - 1);
          end
        end
        ST_LOAD: begin
          if (tmr_end) begin
            state <= ST_LOAD_REC;
            tmr   <= CW'(HALF - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_LOAD_REC: begin
          if (tmr_end) state <= ST_FIN;
          else         tmr   <= tmr - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dacw_pin_reg.sv
module dacw_pin_reg
  import dacw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state,
  input  logic       sclk_low,
  input  logic       sdi_bit,
  output logic       cs_n,
  output logic       ld_n,
  output logic       clr_n,
  output logic       sclk,
  output logic       sdi,
  output logic       done
);

  logic cs_n_d, ld_n_d, clr_n_d, sclk_d, sdi_d, done_d;

  always_comb begin
    cs_n_d  = !(state == ST_SETUP || state == ST_SHIFT ||
                state == ST_LOAD  || state == ST_LOAD_REC);
    ld_n_d  = (state != ST_LOAD);
    clr_n_d = (state != ST_CLR);
    sclk_d  = !((state == ST_SHIFT) && sclk_low);
    sdi_d   = (state == ST_SETUP || state == ST_SHIFT) ? sdi_bit : 1'b0;
    done_d  = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n  <= 1'b1;
      ld_n  <= 1'b1;
      clr_n <= 1'b1;
      sclk  <= 1'b1;
      sdi   <= 1'b0;
      done  <= 1'b0;
    end else begin
      cs_n  <= cs_n_d;
      ld_n  <= ld_n_d;
      clr_n <= clr_n_d;
      sclk  <= sclk_d;
      sdi   <= sdi_d;
      done  <= done_d;
    end
  end

endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
#(
  parameter int CLK_DIV  = 32,
  parameter int CLR_W    = 16,
  parameter int LD_W     = 16,
  parameter int CS_SETUP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_clear,
  input  logic              req_clr_mid,
  output logic              busy,
  output logic              done,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_cs_n,
  output logic              dac_ld_n,
  output logic              dac_clr_n,
  output logic              dac_clrsel
);

  localparam int HALF = CLK_DIV / 2;
  localparam int BW   = $clog2(FRAME_W);

  seq_state_t         state;
  logic               fire;
  logic [FRAME_W-1:0] frame;
  logic               sclk_low;
  logic [BW-1:0]      bit_idx;
  logic               last_tick;
  logic               sdi_bit;

  assign busy    = (state != ST_IDLE);
  assign fire    = req_valid && !busy;
  assign sdi_bit = frame[BW'(FRAME_W - 1) - bit_idx];

  dacw_req_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .in_chan (req_chan),
    .in_code (req_code),
    .in_mid  (req_clr_mid),
    .frame   (frame),
    .clrsel  (dac_clrsel)
  );

  dacw_bit_timer #(
    .CLK_DIV (CLK_DIV),
    .NBITS   (FRAME_W)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .run       (state == ST_SHIFT),
    .sclk_low  (sclk_low),
    .bit_idx   (bit_idx),
    .last_tick (last_tick)
  );

  dacw_seq #(
    .CLR_W    (CLR_W),
    .LD_W     (LD_W),
    .CS_SETUP (CS_SETUP),
    .HALF     (HALF)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .want_clear (req_clear),
    .shift_last (last_tick),
    .state      (state)
  );

  dacw_pin_reg u_pins (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .sclk_low (sclk_low),
    .sdi_bit  (sdi_bit),
    .cs_n     (dac_cs_n),
    .ld_n     (dac_ld_n),
    .clr_n    (dac_clr_n),
    .sclk     (dac_sclk),
    .sdi      (dac_sdi),
    .done     (done)
  );

endmodule

// File: rtl/dacw_ctrl_chk.sv
module dacw_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic dac_sclk,
  input logic dac_sdi,
  input logic dac_cs_n,
  input logic dac_ld_n,
  input logic dac_clr_n,
  input logic dac_clrsel
);

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_cs_n && dac_ld_n && dac_clr_n && dac_sclk && !dac_sdi)); // R4

  AST_SDI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sclk) |-> $stable(dac_sdi)); // R3

  AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !dac_sclk |-> !dac_cs_n); // R7

  AST_CLEAR_OUTSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !dac_clr_n |-> dac_cs_n); // R5

  AST_LOAD_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !dac_ld_n |-> !dac_cs_n); // R8

  AST_CS_RELEASE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_cs_n) |-> $past(dac_ld_n)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done |-> (dac_cs_n && !busy)); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy); // R12

  AST_CLRSEL_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dac_clrsel)); // R6

endmodule

bind dacw_ctrl dacw_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .dac_sclk   (dac_sclk),
  .dac_sdi    (dac_sdi),
  .dac_cs_n   (dac_cs_n),
  .dac_ld_n   (dac_ld_n),
  .dac_clr_n  (dac_clr_n),
  .dac_clrsel (dac_clrsel)
);

// File: tb/test_dacw_ctrl.sv
module test_dacw_ctrl;

  localparam int CLK_DIV  = 4;
  localparam int HALF     = CLK_DIV / 2;
  localparam int CLR_W    = 3;
  localparam int LD_W     = 2;
  localparam int CS_SETUP = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [11:0] req_code = '0;
  logic        req_clear = 1'b0;
  logic        req_clr_mid = 1'b0;
  logic        busy, done, dac_sclk, dac_sdi, dac_cs_n, dac_ld_n, dac_clr_n, dac_clrsel;

  int nchecks = 0;
  int nfail   = 0;

  always #5 clk = ~clk;

  dacw_ctrl #(
    .CLK_DIV  (CLK_DIV),
    .CLR_W    (CLR_W),
    .LD_W     (LD_W),
    .CS_SETUP (CS_SETUP)
  ) i_dacw_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_code    (req_code),
    .req_clear   (req_clear),
    .req_clr_mid (req_clr_mid),
    .busy        (busy),
    .done        (done),
    .dac_sclk    (dac_sclk),
    .dac_sdi     (dac_sdi),
    .dac_cs_n    (dac_cs_n),
    .dac_ld_n    (dac_ld_n),
    .dac_clr_n   (dac_clr_n),
    .dac_clrsel  (dac_clrsel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expectations for the write in flight
  logic [1:0]  exp_chan;
  logic [11:0] exp_code;
  logic        exp_clear, exp_mid;
  int          n_sent = 0;
  int          n_done = 0;

  // converter model and pin-timing monitor, sampled on the falling clock edge
  logic        p_sclk = 1'b1, p_cs = 1'b1, p_ld = 1'b1, p_clr = 1'b1, p_done = 1'b0;
  logic [15:0] sr;
  int          nbits, low_run, high_run, setup_run, clr_run, ld_run;
  logic        clr_seen, ld_seen, sdi_at_fall;

  always @(negedge clk) begin
    if (!rst) begin
      if (!busy)
        chk(dac_cs_n && dac_ld_n && dac_clr_n && dac_sclk && !dac_sdi, "R4 idle levels",
            {dac_cs_n, dac_ld_n, dac_clr_n, dac_sclk, dac_sdi}, 5'b11110);
      // clear pulse
      if (!dac_clr_n) begin
        if (p_clr) clr_run = 0;
        clr_run++;
      end
      if (dac_clr_n && !p_clr) begin
        chk(clr_run == CLR_W, "R5 clear width", clr_run, CLR_W);
        chk(dac_cs_n, "R5 clear outside chip-select", dac_cs_n, 1);
        chk(dac_clrsel == exp_mid, "R6 clear level at clear", dac_clrsel, exp_mid);
        clr_seen = 1'b1;
      end
      // chip-select fall
      if (!dac_cs_n && p_cs) begin
        chk(clr_seen == exp_clear, "R5 clear before chip-select", clr_seen, exp_clear);
        chk(dac_clr_n, "R5 clear high at chip-select", dac_clr_n, 1);
        setup_run = 0; nbits = 0; sr = '0; ld_seen = 1'b0;
      end
      if (!dac_cs_n && dac_sclk && nbits == 0 && p_sclk) setup_run++;
      // serial clock edges
      if (p_sclk && !dac_sclk) begin
        if (nbits == 0) chk(setup_run == CS_SETUP, "R7 chip-select setup", setup_run, CS_SETUP);
        else            chk(high_run == HALF, "R3 high phase", high_run, HALF);
        low_run = 1;
        sdi_at_fall = dac_sdi;
      end else if (!dac_sclk) low_run++;
      if (!p_sclk && dac_sclk) begin
        chk(low_run == HALF, "R3 low phase", low_run, HALF);
        chk(dac_sdi == sdi_at_fall, "R3 data stable over low phase", dac_sdi, sdi_at_fall);
        sr = {sr[14:0], dac_sdi};
        nbits++;
        high_run = 1;
      end else if (dac_sclk) high_run++;
      // load strobe
      if (!dac_ld_n && p_ld) begin
        chk(nbits == 16, "R7 bit count at load", nbits, 16);
        chk(sr[15:14] == exp_chan, "R2 channel field", sr[15:14], exp_chan);
        chk(sr[13:12] == 2'b00, "R1 zero pad", sr[13:12], 0);
        chk(sr[11:0] == exp_code, "R1 code field", sr[11:0], exp_code);
        chk(!dac_cs_n, "R8 load inside chip-select", dac_cs_n, 0);
        ld_run = 0;
      end
      if (!dac_ld_n) ld_run++;
      if (dac_ld_n && !p_ld) begin
        chk(ld_run == LD_W, "R8 load width", ld_run, LD_W);
        ld_seen = 1'b1;
      end
      // chip-select release
      if (dac_cs_n && !p_cs) begin
        chk(ld_seen, "R8 load before release", ld_seen, 1);
        chk(done && !busy, "R9 done at release", {done, busy}, 2'b10);
        clr_seen = 1'b0;
      end
      if (done) begin
        chk(!p_done, "R9 done single cycle", p_done, 0);
        n_done++;
      end
      p_sclk = dac_sclk; p_cs = dac_cs_n; p_ld = dac_ld_n; p_clr = dac_clr_n; p_done = done;
    end
  end

  task automatic send(input logic [1:0] ch, input logic [11:0] code,
                      input logic clr, input logic mid);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_chan = ch; exp_code = code; exp_clear = clr; exp_mid = mid;
    req_valid = 1'b1; req_chan = ch; req_code = code; req_clear = clr; req_clr_mid = mid;
    n_sent++;
    @(negedge clk);
    chk(busy, "R12 busy after accept", busy, 1);
    // junk while busy: must be ignored (R10) and must not reach the frame (R11)
    req_chan = ~ch; req_code = ~code; req_clear = ~clr; req_clr_mid = ~mid;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(dac_clrsel == mid, "R6 clear level follows request", dac_clrsel, mid);
    chk(!busy, "R12 busy low after write", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R4 reset busy/done", {busy, done}, 0);
    chk(dac_cs_n && dac_ld_n && dac_clr_n && dac_sclk && !dac_sdi, "R4 reset pins",
        {dac_cs_n, dac_ld_n, dac_clr_n, dac_sclk, dac_sdi}, 5'b11110);
    chk(dac_clrsel, "R6 reset clear level", dac_clrsel, 1);
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 48; k++) begin
        logic [11:0] code;
        if (k < 12)       code = 12'(1 << k);
        else if (k == 12) code = 12'h000;
        else if (k == 13) code = 12'hFFF;
        else              code = 12'((k * 683 + ch * 97) % 4096);
        send(2'(ch), code, (k % 3) == 0, k[2]);
      end
    end
    repeat (20) @(negedge clk);
    chk(n_done == n_sent, "R10 one write per accepted request", n_done, n_sent);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", n_done, n_sent);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule